// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes one PWM waveform and distributes it over four output pins, named A to D. Each pin has its own steering enable. A steered pin carries the PWM waveform, inverted or not according to a two-bit polarity selector. A pin that is not steered carries its general-purpose port data bit. Steering applies only when the capture/compare unit is in PWM mode (mode qualifier `2'b11`) and the output configuration selects single-output operation (`2'b00`). In any other combination every pin falls back to port data.

Software writes an 8-bit control word. Bits 3:0 hold the enables, one per pin, with bit 0 for A up to bit 3 for D. Bit 4 is the update-timing flag, and bits 7:5 are unused. With the flag clear, a write changes the live enables at the next clock edge. With the flag set, the write is parked in a shadow copy. It moves into the live enables on the clock edge where the one-cycle period-start strobe is high. This lets a steering change land on a clean PWM period boundary. The read port always shows the last written word, even while that word is still pending.

Top module: `pwm_steer_unit`

## Requirements
- R1: After reset the read port returns `8'h01`. The live enables are A=1 and B, C, D=0, and the update-timing flag is 0.
- R2: While steering is active, a pin whose live enable is 1 drives the PWM input through its polarity, and a pin whose enable is 0 drives its port data bit. Both paths are combinational from the current inputs.
- R3: Polarity selector encoding, where "low" means the pin drives the inverted PWM input. `00` makes all pins high-active. `01` makes A and C high-active and B and D low-active. `10` makes A and C low-active and B and D high-active. `11` makes all pins low-active.
- R4: Steering is active only when the mode qualifier is `2'b11` and the output configuration is `2'b00`. In every other combination, all four pins equal port data, whatever the enables hold.
- R5: A write with bit 4 clear makes bits 3:0 the live enables from the clock edge that samples the write. This also applies when an earlier write is still pending.
- R6: A write with bit 4 set leaves the live enables unchanged until a clock edge at which the period-start strobe is high. At that edge they take bits 3:0 of the last written word.
- R7: When a write with bit 4 set and the period-start strobe fall on the same edge, the newly written enables become live at that edge.
- R8: The read port returns bits 4:0 of the last written word, with bits 7:5 forced to 0. This holds from the edge that samples the write, including while the write is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 8 | Control word: [4] timing flag, [3:0] enables D..A |
| rd_data | output | 8 | Last written control word, upper bits 0 |
| mode_sel | input | 2 | Mode qualifier, `11` = PWM |
| out_cfg | input | 2 | Output configuration, `00` = single output |
| pol_sel | input | 2 | Polarity selector |
| pwm_in | input | 1 | PWM waveform |
| period_start | input | 1 | One-cycle strobe at each PWM period start |
| port_data | input | 4 | Port data per pin, bit 0 = A |
| pin_out | output | 4 | Pin outputs, bit 0 = A |

## Verification
The pin outputs depend combinationally on the polarity, mode, PWM and port inputs, so the bench changes those mid-cycle and samples 1 ns later without crossing a clock edge. Enables and the read word are registered once. Writes and strobes are therefore driven at a falling edge, and results are sampled at the next falling edge, half a cycle after the capturing rising edge. For sync-mode writes, the bench samples again at falling edges where no strobe has yet been given, which confirms that the live enables hold. It then checks the edge right after the single strobe cycle.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int STEER_PINS = 4;
  localparam int CTRL_W     = 8;
  localparam logic [1:0] MODE_PWM   = 2'b11;
  localparam logic [1:0] CFG_SINGLE = 2'b00;

  // Even pins (A, C) follow pol[1]; odd pins (B, D) follow pol[0].
  function automatic logic pin_inverted(input logic [1:0] pol, input int idx);
    return (idx % 2 == 1) ? pol[0] : pol[1];
  endfunction
endpackage

// File: rtl/steer_rst_sync.sv
module steer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/steer_ctrl_reg.sv
module steer_ctrl_reg #(
  parameter int NPINS  = 4,
  parameter int DATA_W = 8,
  parameter logic [NPINS-1:0] RST_EN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              period_start,
  output logic [NPINS:0]    shadow_q,
  output logic [NPINS-1:0]  active_en
);
  localparam int CFG_W = NPINS + 1;
  localparam int SYNC_BIT = NPINS;

  logic [CFG_W-1:0] shadow_d;
  logic [NPINS-1:0] active_d;
  logic             active_ce;

  always_comb begin
    shadow_d  = wr_en ? wr_data[CFG_W-1:0] : shadow_q;
    active_ce = !shadow_d[SYNC_BIT] || period_start;
    active_d  = shadow_d[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= {1'b0, RST_EN};
      active_en <= RST_EN;
    end else begin
      if (wr_en)     shadow_q  <= shadow_d;
      if (active_ce) active_en <= active_d;
    end
  end
endmodule

// File: rtl/steer_polarity.sv
module steer_polarity
  import pwm_steer_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic [1:0]       pol_sel,
  input  logic             pwm_in,
  output logic [NPINS-1:0] pwm_pin
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pol
    assign pwm_pin[i] = pwm_in ^ pin_inverted(pol_sel, i);
  end
endmodule

// File: rtl/steer_pin_mux.sv
module steer_pin_mux #(
  parameter int NPINS = 4
) (
  input  logic             steer_on,
  input  logic [NPINS-1:0] enable,
  input  logic [NPINS-1:0] pwm_pin,
  input  logic [NPINS-1:0] port_data,
  output logic [NPINS-1:0] pin_out
);
  for (genvar i = 0; i < NPINS; i++) begin : g_mux
    assign pin_out[i] = (steer_on && enable[i]) ? pwm_pin[i] : port_data[i];
  end
endmodule

// File: rtl/pwm_steer_unit.sv
module pwm_steer_unit
  import pwm_steer_pkg::*;
#(
  parameter int NPINS  = STEER_PINS,
  parameter int DATA_W = CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        mode_sel,
  input  logic [1:0]        out_cfg,
  input  logic [1:0]        pol_sel,
  input  logic              pwm_in,
  input  logic              period_start,
  input  logic [NPINS-1:0]  port_data,
  output logic [NPINS-1:0]  pin_out
);
  localparam int CFG_W = NPINS + 1;
  localparam int PAD_W = DATA_W - CFG_W;

  logic             rst_sync_n;
  logic [CFG_W-1:0] shadow_q;
  logic [NPINS-1:0] active_en;
  logic [NPINS-1:0] pwm_pin;
  logic             steer_on;

  steer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  steer_ctrl_reg #(.NPINS(NPINS), .DATA_W(DATA_W), .RST_EN(1)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .period_start (period_start),
    .shadow_q     (shadow_q),
    .active_en    (active_en)
  );

  steer_polarity #(.NPINS(NPINS)) u_pol (
    .pol_sel (pol_sel),
    .pwm_in  (pwm_in),
    .pwm_pin (pwm_pin)
  );

  assign steer_on = (mode_sel == MODE_PWM) && (out_cfg == CFG_SINGLE);

  steer_pin_mux #(.NPINS(NPINS)) u_mux (
    .steer_on  (steer_on),
    .enable    (active_en),
    .pwm_pin   (pwm_pin),
    .port_data (port_data),
    .pin_out   (pin_out)
  );

  assign rd_data = {{PAD_W{1'b0}}, shadow_q};
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
  parameter int NPINS  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        mode_sel,
  input logic [1:0]        out_cfg,
  input logic              period_start,
  input logic [NPINS-1:0]  port_data,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  act_en
);
  localparam int SB = NPINS;

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:SB+1] == '0); // R8

  AST_RD_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[SB:0] == $past(wr_data[SB:0])); // R8

  AST_OFF_PORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_sel == 2'b11 && out_cfg == 2'b00) |-> pin_out == port_data); // R4

  AST_DISABLED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ port_data) & ~act_en) == '0); // R2

  AST_IMMEDIATE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[SB]) |=> act_en == $past(wr_data[NPINS-1:0])); // R5

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && (wr_en ? wr_data[SB] : rd_data[SB])) |=> $stable(act_en)); // R6

  AST_SYNC_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && wr_en && wr_data[SB]) |=> act_en == $past(wr_data[NPINS-1:0])); // R7
endmodule

bind pwm_steer_unit pwm_steer_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .mode_sel     (mode_sel),
  .out_cfg      (out_cfg),
  .period_start (period_start),
  .port_data    (port_data),
  .pin_out      (pin_out),
  .act_en       (active_en)
);

// File: tb/tb_pwm_steer_unit.sv
`timescale 1ns/1ps
module tb_pwm_steer_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [1:0] mode_sel, out_cfg, pol_sel;
  logic       pwm_in, period_start;
  logic [3:0] port_data, pin_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_steer_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mode_sel(mode_sel), .out_cfg(out_cfg), .pol_sel(pol_sel), .pwm_in(pwm_in),
    .period_start(period_start), .port_data(port_data), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected pins from the requirements: A,C inverted by pol[1], B,D by pol[0].
  function automatic logic [3:0] model(input logic [3:0] en, input logic [1:0] pol,
                                        input logic on, input logic pwm, input logic [3:0] port);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      logic inv;
      inv  = (i == 0 || i == 2) ? pol[1] : pol[0];
      r[i] = (on && en[i]) ? (pwm ^ inv) : port[i];
    end
    return r;
  endfunction

  // Live enables observed through pins: pol 00, pwm 1, port 0.
  task automatic probe(input string req, input logic [3:0] exp_en);
    pol_sel = 2'b00; pwm_in = 1'b1; port_data = 4'h0; #1;
    chk(req, {4'h0, pin_out}, {4'h0, exp_en});
  endtask

  task automatic write(input logic [7:0] d, input logic strobe);
    @(negedge clk); wr_en = 1'b1; wr_data = d; period_start = strobe;
    @(negedge clk); wr_en = 1'b0; period_start = 1'b0;
  endtask

  // Sweep polarity, PWM level and port data for fixed enables (R2, R3).
  task automatic sweep(input logic [3:0] en);
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 16; d++) begin
          pol_sel = p[1:0]; pwm_in = w[0]; port_data = d[3:0]; #1;
          chk((p == 0 && w == 1) ? "R2" : "R3", {4'h0, pin_out},
              {4'h0, model(en, p[1:0], 1'b1, w[0], d[3:0])});
        end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; mode_sel = 2'b11; out_cfg = 2'b00;
    pol_sel = 2'b00; pwm_in = 1'b0; period_start = 1'b0; port_data = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", rd_data, 8'h01);
    probe("R1", 4'b0001);

    // R5 immediate writes over all enable patterns, R2/R3 sweep for each
    for (int e = 0; e < 16; e++) begin
      write({4'h0, e[3:0]}, 1'b0);
      probe("R5", e[3:0]);
      sweep(e[3:0]);
    end

    // R4 mode qualifier and configuration gate
    write(8'h0F, 1'b0);
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 16; d += 5) begin
          mode_sel = m[1:0]; out_cfg = c[1:0]; pol_sel = 2'b00; pwm_in = 1'b1;
          port_data = d[3:0]; #1;
          chk("R4", {4'h0, pin_out},
              {4'h0, model(4'hF, 2'b00, (m == 3 && c == 0), 1'b1, d[3:0])});
        end
    mode_sel = 2'b11; out_cfg = 2'b00;

    // R6 sync write held until strobe; R8 read shows pending word
    write(8'h03, 1'b0);
    write(8'hF6, 1'b0);           // sync, enables 0110, upper bits dropped
    chk("R8", rd_data, 8'h16);
    probe("R6", 4'b0011);
    repeat (3) @(negedge clk);
    probe("R6", 4'b0011);
    period_start = 1'b1; @(negedge clk); period_start = 1'b0;
    probe("R6", 4'b0110);

    // R7 write and strobe on the same edge
    write(8'h19, 1'b1);
    probe("R7", 4'b1001);
    write(8'h13, 1'b0);
    probe("R7", 4'b1001);
    write(8'h1C, 1'b1);           // overrides pending 0011
    probe("R7", 4'b1100);

    // R5 immediate write overrides a pending sync write
    write(8'h1F, 1'b0);
    probe("R6", 4'b1100);
    write(8'h05, 1'b0);
    probe("R5", 4'b0101);
    chk("R8", rd_data, 8'h05);
    write(8'hFF, 1'b0);
    chk("R8", rd_data, 8'h1F);

    // R1 reset again restores defaults
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", rd_data, 8'h01);
    probe("R1", 4'b0001);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule